// File: doc/BRIEF.md
# Descriptor Ring Pointer Controller

This block is the register front end of a descriptor-driven SMBus master. Software fills a ring of descriptors in memory, moves a head pointer inside the control register to mark new work, and sets a start bit. The block keeps its own tail pointer. It hands one descriptor index at a time to the transaction engine and waits for that engine's done pulse. It then steps the tail forward around the ring.

Each finished descriptor can raise a completion interrupt, and a failed one can raise an error interrupt. Both are sticky status bits that software clears by writing ones. The interrupt line is their OR. The ring length is programmable as entries minus one. Descriptor memory access is reduced to an index plus a one-cycle valid strobe.

Top module: `ring_ptr_ctrl`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the size register reads DEF_ENTRIES-1 (1 by default), and `desc_valid` and `irq` are low.
- R2: Register map on `cfg_addr` (byte offsets): 0x0 control = {start at bit 0, error interrupt enable at bit 4, head in bits 23:16}; 0x4 status = {in-progress at bit 0, error status at bit 4, completion status at bit 5, tail in bits 23:16}; 0x8 size = entries minus one in bits 7:0. All other bits, and any other offset, read 0. Writes to other offsets change nothing.
- R3: When start is 1, tail differs from head, and no descriptor is outstanding, `desc_valid` is high for exactly one cycle with `desc_idx` equal to the tail. At most one descriptor is outstanding at a time.
- R4: A done pulse is accepted only while a descriptor is outstanding. It advances the tail by one and wraps from the size value to 0. A done pulse with nothing outstanding changes nothing.
- R5: The in-progress bit is 1 while a descriptor is outstanding or while start is 1 with tail different from head. It is 0 once the tail reaches the head.
- R6: With start at 0, no descriptor is issued even when head and tail differ.
- R7: An accepted done with `eng_irq_req` high sets the completion status bit.
- R8: An accepted done with `eng_err` high sets the error status bit only when the error interrupt enable is 1. Otherwise the error bit is left unchanged.
- R9: Writing 1 to status bit 5 or 4 clears that bit, and writing 0 leaves it. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: `irq` is the OR of the completion and error status bits, in the same cycle when IRQ_REG is 0.
- R11: After the size register is rewritten, the tail wraps at the new entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| desc_valid | output | 1 | One-cycle strobe: run the descriptor at `desc_idx` |
| desc_idx | output | PTR_W | Ring index of the descriptor to run |
| eng_done | input | 1 | Engine finished the outstanding descriptor |
| eng_err | input | 1 | Qualifies `eng_done`: the transaction failed |
| eng_irq_req | input | 1 | Qualifies `eng_done`: the descriptor asked for an interrupt |
| irq | output | 1 | Interrupt request |

## Verification
The ring is driven in its default two-entry form through single posts, posts that wrap the tail past the last entry, and a four-entry form that issues three back-to-back descriptors and then wraps. Each of these separates correct modulo stepping from an off-by-one at the size boundary. The done pulse is applied with error and interrupt request in every combination, with the error enable both on and off, so that completion setting and error gating are told apart. A done pulse while idle, a stopped ring with pending work, and a clearing write landing in the same cycle as a set show the ignore cases and the set-over-clear priority. A behavioural model of the ring is compared against every output and the selected register on every clock.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
   // register byte offsets
   localparam int OFS_CTL  = 'h0;
   localparam int OFS_STS  = 'h4;
   localparam int OFS_SIZE = 'h8;

   // field positions shared by control and status views
   localparam int BIT_START = 0;
   localparam int BIT_EIE   = 4;
   localparam int BIT_BUSY  = 0;
   localparam int BIT_ERR   = 4;
   localparam int BIT_CMP   = 5;
   localparam int PTR_LSB   = 16;

   typedef enum logic [1:0] {
      SEL_CTL,
      SEL_STS,
      SEL_SIZE,
      SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/ring_ptr_regs.sv
module ring_ptr_regs
   import ring_ptr_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int PTR_W       = 8,
   parameter int DEF_ENTRIES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [PTR_W-1:0]  tail,
   input  logic              busy,
   input  logic              accept,
   input  logic              eng_err,
   input  logic              eng_irq_req,
   output logic              ctl_start,
   output logic              ctl_eie,
   output logic [PTR_W-1:0]  head,
   output logic [PTR_W-1:0]  size_m1,
   output logic              sts_cmp,
   output logic              sts_err
);
   localparam logic [PTR_W-1:0] SIZE_RST = PTR_W'(DEF_ENTRIES - 1);

   reg_sel_e sel;
   logic     wr_ctl, wr_sts, wr_size;
   logic     cmp_set, err_set, cmp_clr, err_clr;
   logic     unused_wdata;

   always_comb begin
      if      (cfg_addr == ADDR_W'(OFS_CTL))  sel = SEL_CTL;
      else if (cfg_addr == ADDR_W'(OFS_STS))  sel = SEL_STS;
      else if (cfg_addr == ADDR_W'(OFS_SIZE)) sel = SEL_SIZE;
      else                                    sel = SEL_NONE;
   end

   assign wr_ctl  = cfg_wr && (sel == SEL_CTL);
   assign wr_sts  = cfg_wr && (sel == SEL_STS);
   assign wr_size = cfg_wr && (sel == SEL_SIZE);

   assign cmp_set = accept && eng_irq_req;
   assign err_set = accept && eng_err && ctl_eie;
   assign cmp_clr = wr_sts && cfg_wdata[BIT_CMP];
   assign err_clr = wr_sts && cfg_wdata[BIT_ERR];
   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_start <= 1'b0;
         ctl_eie   <= 1'b0;
         head      <= '0;
         size_m1   <= SIZE_RST;
         sts_cmp   <= 1'b0;
         sts_err   <= 1'b0;
      end else begin
         if (wr_ctl) begin
            ctl_start <= cfg_wdata[BIT_START];
            ctl_eie   <= cfg_wdata[BIT_EIE];
            head      <= cfg_wdata[PTR_LSB +: PTR_W];
         end
         if (wr_size) size_m1 <= cfg_wdata[PTR_W-1:0];
         // set has priority over a clearing write in the same cycle
         sts_cmp <= cmp_set | (sts_cmp & ~cmp_clr);
         sts_err <= err_set | (sts_err & ~err_clr);
      end
   end

   always_comb begin
      cfg_rdata = '0;
      unique case (sel)
         SEL_CTL: begin
            cfg_rdata[BIT_START]             = ctl_start;
            cfg_rdata[BIT_EIE]               = ctl_eie;
            cfg_rdata[PTR_LSB +: PTR_W]      = head;
         end
         SEL_STS: begin
            cfg_rdata[BIT_BUSY]              = busy;
            cfg_rdata[BIT_ERR]               = sts_err;
            cfg_rdata[BIT_CMP]               = sts_cmp;
            cfg_rdata[PTR_LSB +: PTR_W]      = tail;
         end
         SEL_SIZE: cfg_rdata[PTR_W-1:0]      = size_m1;
         default:  cfg_rdata                 = '0;
      endcase
   end

   // R9: a clearing write with no competing set leaves the bit low
   assert_w1c_cmp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_clr && !accept) |=> !sts_cmp);
   // R7: an accepted done requesting an interrupt is always recorded
   assert_cmp_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && eng_irq_req) |=> sts_cmp);
   // R8: the error bit only rises while the enable was on
   assert_err_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_err) |-> $past(ctl_eie));
endmodule

// File: rtl/ring_ptr_seq.sv
module ring_ptr_seq #(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_start,
   input  logic [PTR_W-1:0] head,
   input  logic [PTR_W-1:0] size_m1,
   input  logic             eng_done,
   output logic             desc_valid,
   output logic [PTR_W-1:0] desc_idx,
   output logic [PTR_W-1:0] tail,
   output logic             busy,
   output logic             accept
);
   logic             outstanding;
   logic             pending;
   logic [PTR_W-1:0] tail_nxt;

   assign pending    = ctl_start && (tail != head);
   assign desc_valid = pending && !outstanding;
   assign desc_idx   = tail;
   assign accept     = outstanding && eng_done;
   assign busy       = outstanding || pending;
   assign tail_nxt   = (tail == size_m1) ? '0 : PTR_W'(tail + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail        <= '0;
         outstanding <= 1'b0;
      end else if (desc_valid) begin
         outstanding <= 1'b1;
      end else if (accept) begin
         outstanding <= 1'b0;
         tail        <= tail_nxt;
      end
   end

   // R3: an issue strobe never lasts two cycles
   assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |=> !desc_valid);
   // R4: without a done pulse the tail holds
   assert_tail_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_done |=> $stable(tail));
   // R5: an issue is always reported as in progress
   assert_busy_on_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> busy);
endmodule

// File: rtl/ring_ptr_irq.sv
module ring_ptr_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sts_cmp,
   input  logic sts_err,
   output logic irq
);
   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= sts_cmp | sts_err;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = sts_cmp | sts_err;
      end
   endgenerate
endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl #(
   parameter int ADDR_W      = 4,
   parameter int PTR_W       = 8,
   parameter int DEF_ENTRIES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              desc_valid,
   output logic [PTR_W-1:0]  desc_idx,
   input  logic              eng_done,
   input  logic              eng_err,
   input  logic              eng_irq_req,
   output logic              irq
);
   localparam int MAX_ENTRIES = 1 << PTR_W;

   generate
      if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
         $error("ring_ptr_ctrl: PTR_W must be 1..8");
      end
      if (DEF_ENTRIES < 2 || DEF_ENTRIES > MAX_ENTRIES) begin : g_bad_depth
         $error("ring_ptr_ctrl: DEF_ENTRIES out of range");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ring_ptr_ctrl: ADDR_W must reach offset 0x8");
      end
   endgenerate

   logic             ctl_start, ctl_eie, sts_cmp, sts_err;
   logic             busy, accept;
   logic [PTR_W-1:0] head, size_m1, tail;

   ring_ptr_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .DEF_ENTRIES(DEF_ENTRIES)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tail(tail), .busy(busy),
      .accept(accept), .eng_err(eng_err), .eng_irq_req(eng_irq_req),
      .ctl_start(ctl_start), .ctl_eie(ctl_eie), .head(head), .size_m1(size_m1),
      .sts_cmp(sts_cmp), .sts_err(sts_err));

   ring_ptr_seq #(.PTR_W(PTR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .head(head),
      .size_m1(size_m1), .eng_done(eng_done), .desc_valid(desc_valid),
      .desc_idx(desc_idx), .tail(tail), .busy(busy), .accept(accept));

   ring_ptr_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .sts_cmp(sts_cmp), .sts_err(sts_err), .irq(irq));

   // R10: the interrupt only drops after software wrote a register
   assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(cfg_wr) || $past(cfg_wr, 2)));
   // R6: a stopped ring issues nothing
   assert_stop_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_start |-> !desc_valid);
endmodule

// File: tb/sim_ring_ptr_ctrl.sv
`timescale 1ns/100ps
module sim_ring_ptr_ctrl;
   localparam int AW = 4;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          desc_valid;
   logic [PW-1:0] desc_idx;
   logic          eng_done = 1'b0, eng_err = 1'b0, eng_irq_req = 1'b0;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit run_cmp = 1'b0;

   always #2.5 clk = ~clk;

   ring_ptr_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .desc_valid(desc_valid),
      .desc_idx(desc_idx), .eng_done(eng_done), .eng_err(eng_err),
      .eng_irq_req(eng_irq_req), .irq(irq));

   // ---------------- behavioural reference model ----------------
   int m_head, m_tail, m_size, m_start, m_eie, m_out, m_cmp, m_err;

   function automatic int m_valid();
      return (m_start != 0 && m_tail != m_head && m_out == 0) ? 1 : 0;
   endfunction
   function automatic int m_busy();
      return (m_out != 0 || (m_start != 0 && m_tail != m_head)) ? 1 : 0;
   endfunction
   function automatic logic [31:0] m_read(int a);
      logic [31:0] r = '0;
      if (a == 0) begin
         r[0] = m_start[0]; r[4] = m_eie[0]; r[23:16] = m_head[7:0];
      end else if (a == 4) begin
         r[0] = m_busy() != 0; r[4] = m_err[0]; r[5] = m_cmp[0];
         r[23:16] = m_tail[7:0];
      end else if (a == 8) begin
         r[7:0] = m_size[7:0];
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_head = 0; m_tail = 0; m_size = 1; m_start = 0; m_eie = 0;
         m_out = 0; m_cmp = 0; m_err = 0;
      end else begin
         int acc, eie_old, v;
         acc = (m_out != 0 && eng_done) ? 1 : 0;
         v = m_valid();
         eie_old = m_eie;
         if (v != 0) m_out = 1;
         else if (acc != 0) begin
            m_out = 0;
            m_tail = (m_tail == m_size) ? 0 : m_tail + 1;
         end
         if (cfg_wr && cfg_addr == 4 && cfg_wdata[5]) m_cmp = 0;
         if (cfg_wr && cfg_addr == 4 && cfg_wdata[4]) m_err = 0;
         if (acc != 0 && eng_irq_req) m_cmp = 1;
         if (acc != 0 && eng_err && eie_old != 0) m_err = 1;
         if (cfg_wr && cfg_addr == 0) begin
            m_start = cfg_wdata[0]; m_eie = cfg_wdata[4];
            m_head = int'(cfg_wdata[23:16]);
         end
         if (cfg_wr && cfg_addr == 8) m_size = int'(cfg_wdata[7:0]);
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // every clock: outputs and the selected register against the model
   always @(negedge clk) begin
      if (run_cmp) begin
         chk("model valid R3", {31'b0, desc_valid}, 32'(m_valid()));
         if (m_valid() != 0) chk("model idx R3", 32'(desc_idx), 32'(m_tail));
         chk("model irq R10", {31'b0, irq}, 32'((m_cmp | m_err) != 0));
         chk("model rdata R2", cfg_rdata, m_read(int'(cfg_addr)));
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(int a, logic [31:0] d);
      @(negedge clk); #1;
      cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
      @(negedge clk); #1;
      cfg_wr = 1'b0;
   endtask

   task automatic rd(int a, string tag, logic [31:0] exp);
      @(negedge clk); #1;
      cfg_addr = AW'(a);
      #1;
      chk(tag, cfg_rdata, exp);
   endtask

   task automatic wait_valid(logic [7:0] exp_idx);
      for (int i = 0; i < 20; i++) begin
         if (desc_valid) break;
         @(negedge clk); #1;
      end
      chk("issue R3", {31'b0, desc_valid}, 32'd1);
      chk("index R3", 32'(desc_idx), 32'(exp_idx));
   endtask

   task automatic finish_done(logic e, logic q, logic clr_cmp);
      @(negedge clk); #1;
      eng_done = 1'b1; eng_err = e; eng_irq_req = q;
      if (clr_cmp) begin
         cfg_wr = 1'b1; cfg_addr = AW'(4); cfg_wdata = 32'h20;
      end
      @(negedge clk); #1;
      eng_done = 1'b0; eng_err = 1'b0; eng_irq_req = 1'b0; cfg_wr = 1'b0;
   endtask

   initial begin
      #50000;
      errors++;
      $display("FAIL watchdog R3 act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      run_cmp = 1'b1;
      // R1 reset values
      rd(0, "reset ctl R1", 32'h0);
      rd(4, "reset sts R1", 32'h0);
      rd(8, "reset size R1", 32'h1);
      chk("reset irq R1", {31'b0, irq}, 32'd0);
      rd(12, "unmapped R2", 32'h0);

      wr(4, 32'h0);
      wr(0, 32'h10);
      rd(0, "ctl layout R2", 32'h10);
      // post one descriptor: head first, start second
      wr(0, 32'h0001_0010);
      wr(0, 32'h0001_0011);
      wait_valid(8'd0);
      rd(4, "busy while out R5", 32'h0000_0001);
      finish_done(1'b0, 1'b1, 1'b0);
      rd(4, "tail step cmp R7", 32'h0001_0020);
      chk("irq on cmp R10", {31'b0, irq}, 32'd1);
      wr(4, 32'h20);
      rd(4, "w1c cmp R9", 32'h0001_0000);
      chk("irq cleared R10", {31'b0, irq}, 32'd0);

      // wrap to index 0, error with enable on
      wr(0, 32'h0000_0011);
      wait_valid(8'd1);
      finish_done(1'b1, 1'b0, 1'b0);
      rd(4, "wrap err R4 R8", 32'h0000_0010);
      wr(4, 32'h00);
      rd(4, "write zero keeps R9", 32'h0000_0010);
      wr(4, 32'h10);
      rd(4, "w1c err R9", 32'h0);

      // enable off: error ignored
      wr(0, 32'h0001_0001);
      wait_valid(8'd0);
      finish_done(1'b1, 1'b0, 1'b0);
      rd(4, "err gated R8", 32'h0001_0000);
      chk("no irq gated R8", {31'b0, irq}, 32'd0);

      // done while idle ignored
      finish_done(1'b0, 1'b1, 1'b0);
      rd(4, "idle done R4", 32'h0001_0000);

      // stopped ring with pending work
      wr(0, 32'h0000_0010);
      repeat (3) begin
         @(negedge clk); #1;
         chk("stop no issue R6", {31'b0, desc_valid}, 32'd0);
      end
      rd(4, "stop not busy R5", 32'h0001_0000);

      // set wins over a clear in the same cycle
      wr(0, 32'h0000_0011);
      wait_valid(8'd1);
      finish_done(1'b0, 1'b1, 1'b1);
      rd(4, "set beats clear R9", 32'h0000_0020);
      wr(4, 32'h20);

      // four-entry ring
      wr(8, 32'h3);
      rd(8, "size write R11", 32'h3);
      wr(0, 32'h0003_0011);
      for (int k = 0; k < 3; k++) begin
         wait_valid(8'(k));
         finish_done(1'b0, 1'b0, 1'b0);
      end
      rd(4, "four entry tail R11", 32'h0003_0000);
      wr(0, 32'h0000_0011);
      wait_valid(8'd3);
      finish_done(1'b0, 1'b0, 1'b0);
      rd(4, "four entry wrap R11", 32'h0000_0000);

      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule